// File: doc/BRIEF.md
# Color-Pointer Configuration Register File

This block holds the control registers of a three-channel (red, green, blue) image-sensor front end. A host reaches it over an 8-bit asynchronous parallel bus with active-low chip select, read strobe and write strobe and a 3-bit register address. The write strobe and chip select are brought into the system clock domain before a write is accepted, so the host may run at any timing as long as address and data are held steady around the strobe's rising edge.

Four registers exist once per color: input offset, PGA gain, odd-pixel offset and even-pixel offset. They share one address each. The color copy that a write reaches, and the copy that a read returns, is chosen by a two-bit pointer held in the main configuration register. A second configuration register is decoded into mode outputs: correlated double sampling enable, mono/color, three converter span selects and a clamp mode. The clamp mode combines the sensor reset clock with the line-start input to produce the clamp switch control.

Top module: `color_cfg_regs`

## Requirements
- R1: After reset every register is 0: all reads return 0, pointer is red, CDS off, color mode, line clamp, active channel 0.
- R2: A write takes effect when the write strobe rises while chip select is low; a strobe pulse with chip select high changes nothing.
- R3: The address map is 0 = main configuration, 1 = mode configuration, 2 = input offset, 3 = PGA gain, 4 = odd offset, 5 = even offset; addresses 6 and 7 read 0 and writes to them change nothing.
- R4: Main configuration bits 7:6 are the pointer, 00 = red (copy 0), 01 = green (copy 1), 10 = blue (copy 2); a per-color write lands only in the copy the pointer selects at that write.
- R5: With pointer 11 a per-color write changes no copy and per-color reads return 0.
- R6: A per-color read returns the copy selected by the present pointer value.
- R7: Reserved bits read as 0: main configuration bits 5:0, mode configuration bit 5, PGA gain bits 7:4 (gain uses bits 3:0 only).
- R8: Mode configuration bit 0 drives cds_en, bit 1 mono, bit 2 span_4v, bit 3 span_2v, bit 4 span_ext; each output follows its own bit only.
- R9: active_ch holds the pointer value captured at the latest mode configuration write and does not follow later pointer changes.
- R10: Mode configuration bits 7:6 give clamp_mode; with 00 clamp_sw equals rst_clk while line_start is low and is 0 while line_start is high, with 01 clamp_sw equals rst_clk always, with 10 or 11 clamp_sw is 0.
- R11: rdata_en is 1 exactly while chip select and read strobe are both low; otherwise rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_en | output | 1 | Read data drive enable |
| rst_clk | input | 1 | Sensor reset clock |
| line_start | input | 1 | Start of scan line |
| cds_en | output | 1 | Correlated double sampling enable |
| mono | output | 1 | Single-channel mode |
| span_4v | output | 1 | 4 V converter span |
| span_2v | output | 1 | 2 V converter span |
| span_ext | output | 1 | External-reference span |
| clamp_mode | output | 2 | Clamp mode code |
| active_ch | output | 2 | Channel used in mono mode |
| clamp_sw | output | 1 | Input clamp switch control |

## Verification
The hard case is showing that a per-color write reaches one copy and leaves the other two untouched, because only one copy is visible at a time through the pointer. The stimulus fills all three copies of every per-color register with values unique to color and address, then walks the pointer across all codes and reads every copy back; the reserved pointer code is written to between these passes to show nothing moves. The mono channel capture is reached by moving the pointer after a mode write and confirming active_ch stays put.

// File: rtl/color_cfg_regs.sv
module color_cfg_regs #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_en,
  input  logic          rst_clk,
  input  logic          line_start,
  output logic          cds_en,
  output logic          mono,
  output logic          span_4v,
  output logic          span_2v,
  output logic          span_ext,
  output logic [1:0]    clamp_mode,
  output logic [1:0]    active_ch,
  output logic          clamp_sw
);
  localparam logic [DW-1:0] MODE_MASK = ~(DW'(1) << 5);

  logic [2:0]    wr_sync;
  logic [1:0]    cs_sync;
  logic          wr_stb;
  logic [1:0]    ptr;
  logic [DW-1:0] mode_q;
  logic [1:0]    act_q;
  logic [DW-1:0] in_off [4];
  logic [GW-1:0] gain   [4];
  logic [DW-1:0] odd_off[4];
  logic [DW-1:0] evn_off[4];
  logic [DW-1:0] rmux;
  logic          ptr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sync <= '1;
      cs_sync <= '1;
    end else begin
      wr_sync <= {wr_sync[1:0], wr_n};
      cs_sync <= {cs_sync[0], cs_n};
    end
  end

  assign wr_stb = wr_sync[1] & ~wr_sync[2] & ~cs_sync[1];
  assign ptr_ok = (ptr != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      mode_q <= '0;
      act_q  <= '0;
      for (int i = 0; i < 4; i++) begin
        in_off[i]  <= '0;
        gain[i]    <= '0;
        odd_off[i] <= '0;
        evn_off[i] <= '0;
      end
    end else if (wr_stb) begin
      case (addr)
        AW'(0): ptr <= wdata[DW-1:DW-2];
        AW'(1): begin
          mode_q <= wdata & MODE_MASK;
          act_q  <= ptr;
        end
        AW'(2): if (ptr_ok) in_off[ptr]  <= wdata;
        AW'(3): if (ptr_ok) gain[ptr]    <= wdata[GW-1:0];
        AW'(4): if (ptr_ok) odd_off[ptr] <= wdata;
        AW'(5): if (ptr_ok) evn_off[ptr] <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rmux = {ptr, {(DW-2){1'b0}}};
      AW'(1):  rmux = mode_q;
      AW'(2):  rmux = in_off[ptr];
      AW'(3):  rmux = {{(DW-GW){1'b0}}, gain[ptr]};
      AW'(4):  rmux = odd_off[ptr];
      AW'(5):  rmux = evn_off[ptr];
      default: rmux = '0;
    endcase
  end

  assign rdata_en   = ~cs_n & ~rd_n;
  assign rdata      = rdata_en ? rmux : '0;
  assign cds_en     = mode_q[0];
  assign mono       = mode_q[1];
  assign span_4v    = mode_q[2];
  assign span_2v    = mode_q[3];
  assign span_ext   = mode_q[4];
  assign clamp_mode = mode_q[DW-1:DW-2];
  assign active_ch  = act_q;
  assign clamp_sw   = rst_clk & ((clamp_mode == 2'b00 & ~line_start) | (clamp_mode == 2'b01));
endmodule

module color_cfg_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic [7:0] rdata,
  input logic       rdata_en,
  input logic       wr_stb,
  input logic       line_start,
  input logic [1:0] clamp_mode,
  input logic       clamp_sw,
  input logic [4:0] mode_bits,
  input logic [1:0] active_ch
);
  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> rdata == 8'h00);
  // R7
  gain_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 3'd3 |-> rdata[7:4] == 4'h0);
  // R10
  no_clamp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_mode[1] |-> !clamp_sw);
  // R10
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_mode == 2'b00 && line_start) |-> !clamp_sw);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mode_bits) && $stable(clamp_mode));
  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(active_ch));
endmodule

bind color_cfg_regs color_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .rdata_en(rdata_en),
  .wr_stb(wr_stb), .line_start(line_start), .clamp_mode(clamp_mode),
  .clamp_sw(clamp_sw), .mode_bits({span_ext, span_2v, span_4v, mono, cds_en}),
  .active_ch(active_ch)
);

// File: tb/tb_color_cfg_regs.sv
module tb_color_cfg_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rdata_en, rst_clk = 0, line_start = 0;
  logic cds_en, mono, span_4v, span_2v, span_ext, clamp_sw;
  logic [1:0] clamp_mode, active_ch;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  color_cfg_regs dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en),
    .rst_clk(rst_clk), .line_start(line_start), .cds_en(cds_en), .mono(mono),
    .span_4v(span_4v), .span_2v(span_2v), .span_ext(span_ext),
    .clamp_mode(clamp_mode), .active_ch(active_ch), .clamp_sw(clamp_sw)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    addr = a; wdata = d; cs_n = ~sel; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 0; rd_n = 0;
    #1;
    d = rdata;
    chk("R11 en", int'(rdata_en), 1);
    rd_n = 1; cs_n = 1;
    #1;
    chk("R11 idle", int'({rdata_en, rdata}), 0);
  endtask

  function automatic logic [7:0] pat(input int p, input int a);
    return 8'((p * 37 + a * 11 + 5) ^ (a << 4));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), got); chk("R1 reset read", got, 0);
    end
    chk("R1 reset modes", {cds_en, mono, span_4v, span_2v, span_ext, clamp_mode, active_ch}, 0);

    // R4 fill every copy
    for (int p = 0; p < 3; p++) begin
      bus_wr(3'd0, 8'(p << 6));
      for (int a = 2; a < 6; a++) bus_wr(3'(a), pat(p, a));
    end
    // R5 pointer 11 writes dropped
    bus_wr(3'd0, 8'hC0);
    for (int a = 2; a < 6; a++) bus_wr(3'(a), 8'hEE);
    for (int a = 2; a < 6; a++) begin
      bus_rd(3'(a), got); chk("R5 reserved pointer read", got, 0);
    end
    // R2 write with chip select high ignored
    bus_wr(3'd0, 8'h40, 1'b0);
    bus_rd(3'd0, got); chk("R2 cs high ignored", got, 8'hC0);
    // R3 addresses 6 and 7
    bus_wr(3'd6, 8'hFF); bus_wr(3'd7, 8'hFF);
    bus_rd(3'd6, got); chk("R3 addr6", got, 0);
    bus_rd(3'd7, got); chk("R3 addr7", got, 0);
    // R6 R4 R7 readback per pointer
    for (int p = 0; p < 3; p++) begin
      bus_wr(3'd0, 8'(p << 6) | 8'h3F);
      bus_rd(3'd0, got); chk("R7 main reserved", got, p << 6);
      for (int a = 2; a < 6; a++) begin
        exp = pat(p, a);
        if (a == 3) exp = exp & 8'h0F;
        bus_rd(3'(a), got); chk("R6 R4 per-color copy", got, exp);
      end
    end

    // R8 R7 R10 sweep of mode register
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd1, 8'(v));
      bus_rd(3'd1, got); chk("R7 mode readback", got, v & 8'hDF);
      chk("R8 decode", {span_ext, span_2v, span_4v, mono, cds_en}, v & 31);
      chk("R10 clamp code", clamp_mode, v >> 6);
    end

    // R9 mono channel capture
    for (int p = 0; p < 3; p++) begin
      bus_wr(3'd0, 8'(p << 6));
      bus_wr(3'd1, 8'h02);
      bus_wr(3'd0, 8'(((p + 1) % 3) << 6));
      chk("R9 active channel", active_ch, p);
      chk("R9 mono", mono, 1);
    end

    // R10 clamp switch truth
    for (int m = 0; m < 4; m++) begin
      bus_wr(3'd1, 8'(m << 6));
      for (int ls = 0; ls < 2; ls++)
        for (int rc = 0; rc < 2; rc++) begin
          @(negedge clk);
          line_start = 1'(ls); rst_clk = 1'(rc);
          #1;
          if (m == 0) chk("R10 line clamp", clamp_sw, rc & (1 - ls));
          else if (m == 1) chk("R10 pixel clamp", clamp_sw, rc);
          else chk("R10 no clamp", clamp_sw, 0);
        end
    end
    line_start = 0; rst_clk = 0;

    // R1 reset again clears
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    bus_rd(3'd2, got); chk("R1 reset clears copy", got, 0);
    bus_rd(3'd1, got); chk("R1 reset clears mode", got, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule